// File: doc/BRIEF.md
# Tag-Steered Quadword Receive Channel

This channel empties a 32-bit word FIFO into memory in 128-bit quadwords. What to write and where comes from the stream itself. Whenever the channel has no quadwords left to move, it takes the next four FIFO words as a tag. The tag gives a quadword count, a destination address and a set of control bits. The payload quadwords that follow the tag are packed from four FIFO words each and written out one at a time. The address steps by 16 bytes for each quadword.

Software programs a control register, an address register and a quadword-count register while the channel is idle. It then sets the start bit. A count loaded before start is drained before the first tag is read. The channel stops when a block tagged as last has drained, or when the tag-interrupt bit is set after a tag has been read and the block count reaches zero. On stopping it clears the start bit and pulses `irq` for one cycle.

State machine states and transitions:
- `ST_IDLE`: waits for the start bit, then goes to `ST_CHECK` and clears the last-block and chained flags.
- `ST_CHECK`: chooses what happens next.
  - If the count is non-zero and at least four words are buffered, it loads a burst length and goes to `ST_XFER`.
  - If the count is zero and the stop rules apply, it goes to `ST_STOP`.
  - If the count is zero, no stop rule applies and at least four words are buffered, it goes to `ST_TAG`.
  - Otherwise it stays in `ST_CHECK`.
- `ST_TAG`: pops four words and then goes to `ST_TAGLD`.
- `ST_TAGLD`: applies the tag and returns to `ST_CHECK`.
- `ST_XFER`: pops four words and then goes to `ST_WRITE`.
- `ST_WRITE`: issues one memory write. It goes back to `ST_XFER` while burst quadwords remain, otherwise to `ST_CHECK`.
- `ST_STOP`: pulses `irq`, clears the start bit and goes to `ST_IDLE`.

Top module: `qdr_receiver`

## Requirements
- R1: After reset the control, address and count registers read zero, and `irq`, `mem_we` and `fifo_pop` are low.
- R2: A tag is taken only when the count is zero and `fifo_count` is at least 4. Tag word 0 bits 15:0 become the count, and tag word 1 becomes the address. Tag words 2 and 3 are discarded.
- R3: When a tag is loaded, control bits 31:16 take tag word 0 bits 31:16, and control bits 15:0 keep their value.
- R4: Each quadword is four consecutive FIFO words, with the first word in bits 31:0. It is written to the current address. The address then grows by 16 and the count drops by 1.
- R5: A burst moves min(count, `fifo_count`/4) quadwords. The channel never pops an empty FIFO, and it waits without popping while fewer than 4 words are buffered.
- R6: If tag word 0 bit 30 (last block) was set, then once the count reaches zero the channel clears control bit 8 (start) and raises `irq` for exactly one cycle.
- R7: If control bit 31 is set after a tag has been read in the current run, the channel stops with `irq` when the count reaches zero. Words still in the FIFO are left unread.
- R8: Control bit 31 set by software at start has no effect before the first tag of the run, so the channel still reads that tag.
- R9: Setting the start bit clears the last-block and chained flags from the previous run.
- R10: Register writes are accepted only while idle (`reg_sel` 0 = control, 1 = address, 2 = count) and are ignored while the channel runs.
- R11: A non-zero count programmed before start is drained to the programmed address before any tag is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fifo_data | input | 32 | Word at the head of the FIFO |
| fifo_count | input | CNT_W | Number of words buffered |
| fifo_pop | output | 1 | Consume the head word this cycle |
| mem_we | output | 1 | Quadword write strobe |
| mem_addr | output | ADDR_W | Byte address of the write |
| mem_wdata | output | 128 | Quadword data |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| ctrl_o | output | 32 | Control register |
| addr_o | output | ADDR_W | Address register |
| qwc_o | output | 16 | Quadword count register |
| irq | output | 1 | Completion pulse |

## Verification
The bench builds the channel with FIFO_DEPTH = 32, which makes `fifo_count` six bits wide. The bench-side FIFO is filled in small pieces, so a burst can be cut short by the fill level. This also creates a mid-block stall, in which `ST_CHECK` waits with fewer than four words buffered while register writes arrive. With ADDR_W = 32, tag word 1 maps onto the address register in full, so the full-width address field can be checked.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_TAG,
        ST_TAGLD,
        ST_XFER,
        ST_WRITE,
        ST_STOP
    } qdr_state_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_QWC  = 2'd2;

    localparam int START_BIT = 8;
    localparam int TIRQ_BIT  = 31;
    localparam int LAST_BIT  = 30;
endpackage

// File: rtl/qdr_packer.sv
module qdr_packer #(
    parameter int WORD_W = 32,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift_en,
    input  logic [WORD_W-1:0]         word_i,
    output logic [LANES*WORD_W-1:0]   qw_o,
    output logic                      last_o
);
    localparam int IDX_W = $clog2(LANES);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= '0;
        else if (shift_en)
            idx_q <= (idx_q == IDX_W'(LANES-1)) ? '0 : idx_q + 1'b1;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [WORD_W-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lane_q <= '0;
            else if (shift_en && idx_q == IDX_W'(g))
                lane_q <= word_i;
        end
        assign qw_o[g*WORD_W +: WORD_W] = lane_q;
    end

    assign last_o = shift_en && (idx_q == IDX_W'(LANES-1));
endmodule

// File: rtl/qdr_burst_calc.sv
module qdr_burst_calc #(
    parameter int CNT_W = 8,
    parameter int QWC_W = 16
) (
    input  logic [QWC_W-1:0] qwc_i,
    input  logic [CNT_W-1:0] fill_i,
    output logic [QWC_W-1:0] burst_o
);
    localparam int CMP_W = (QWC_W > CNT_W) ? QWC_W : CNT_W;

    logic [CMP_W-1:0] avail_qw;
    logic [CMP_W-1:0] want_qw;

    always_comb begin
        avail_qw = CMP_W'(fill_i >> 2);
        want_qw  = CMP_W'(qwc_i);
        burst_o  = (want_qw < avail_qw) ? qwc_i : QWC_W'(avail_qw);
    end
endmodule

// File: rtl/qdr_receiver.sv
module qdr_receiver
    import qdr_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       fifo_data,
    input  logic [CNT_W-1:0]  fifo_count,
    output logic              fifo_pop,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [127:0]      mem_wdata,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       ctrl_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [15:0]       qwc_o,
    output logic              irq
);
    localparam int QWC_W   = 16;
    localparam int QW_BYTES = 16;
    localparam int TAG_MIN = 4;

    qdr_state_e state_q, state_d;

    logic [31:0]       ctrl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [QWC_W-1:0]  qwc_q;
    logic [QWC_W-1:0]  burst_q;
    logic              last_q;
    logic              chain_q;

    logic              shift_en;
    logic [127:0]      qw;
    logic              pack_last;
    logic [QWC_W-1:0]  burst_len;
    logic              have_tag_words;
    logic              stop_now;

    qdr_packer #(.WORD_W(32), .LANES(4)) u_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .word_i   (fifo_data),
        .qw_o     (qw),
        .last_o   (pack_last)
    );

    qdr_burst_calc #(.CNT_W(CNT_W), .QWC_W(QWC_W)) u_burst (
        .qwc_i   (qwc_q),
        .fill_i  (fifo_count),
        .burst_o (burst_len)
    );

    assign have_tag_words = (fifo_count >= CNT_W'(TAG_MIN));
    assign stop_now       = last_q || (chain_q && ctrl_q[TIRQ_BIT]);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (ctrl_q[START_BIT]) state_d = ST_CHECK;
            ST_CHECK: begin
                if (qwc_q != '0) begin
                    if (have_tag_words) state_d = ST_XFER;
                end else if (stop_now) begin
                    state_d = ST_STOP;
                end else if (have_tag_words) begin
                    state_d = ST_TAG;
                end
            end
            ST_TAG:   if (pack_last) state_d = ST_TAGLD;
            ST_TAGLD: state_d = ST_CHECK;
            ST_XFER:  if (pack_last) state_d = ST_WRITE;
            ST_WRITE: state_d = (burst_q == QWC_W'(1)) ? ST_CHECK : ST_XFER;
            ST_STOP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        shift_en = 1'b0;
        mem_we   = 1'b0;
        irq      = 1'b0;
        unique case (state_q)
            ST_TAG, ST_XFER: shift_en = 1'b1;
            ST_WRITE:        mem_we   = 1'b1;
            ST_STOP:         irq      = 1'b1;
            default: ;
        endcase
    end

    assign fifo_pop  = shift_en;
    assign mem_addr  = addr_q;
    assign mem_wdata = qw;
    assign ctrl_o    = ctrl_q;
    assign addr_o    = addr_q;
    assign qwc_o     = qwc_q;

    // channel registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            addr_q  <= '0;
            qwc_q   <= '0;
            burst_q <= '0;
            last_q  <= 1'b0;
            chain_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ctrl_q[START_BIT]) begin
                        last_q  <= 1'b0;
                        chain_q <= 1'b0;
                    end else if (reg_we) begin
                        unique case (reg_sel)
                            SEL_CTRL: ctrl_q <= reg_wdata;
                            SEL_ADDR: addr_q <= ADDR_W'(reg_wdata);
                            SEL_QWC:  qwc_q  <= reg_wdata[QWC_W-1:0];
                            default: ;
                        endcase
                    end
                end
                ST_CHECK: begin
                    if (qwc_q != '0 && have_tag_words)
                        burst_q <= burst_len;
                end
                ST_TAGLD: begin
                    qwc_q          <= qw[QWC_W-1:0];
                    addr_q         <= ADDR_W'(qw[63:32]);
                    ctrl_q[31:16]  <= qw[31:16];
                    last_q         <= qw[LAST_BIT];
                    chain_q        <= 1'b1;
                end
                ST_WRITE: begin
                    addr_q  <= addr_q + ADDR_W'(QW_BYTES);
                    qwc_q   <= qwc_q - 1'b1;
                    burst_q <= burst_q - 1'b1;
                end
                ST_STOP: begin
                    ctrl_q[START_BIT] <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/qdr_receiver_chk.sv
module qdr_receiver_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  fifo_count,
    input logic              fifo_pop,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       ctrl_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [15:0]       qwc_o,
    input logic              irq
);
    assert_pop_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> fifo_count != '0);

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_start_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !ctrl_o[8]);

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> addr_o == $past(mem_addr) + ADDR_W'(16));

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> qwc_o == $past(qwc_o) - 16'd1);

    assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o[8] |-> (!fifo_pop && !mem_we));
endmodule

bind qdr_receiver qdr_receiver_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_count (fifo_count),
    .fifo_pop   (fifo_pop),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .ctrl_o     (ctrl_o),
    .addr_o     (addr_o),
    .qwc_o      (qwc_o),
    .irq        (irq)
);

// File: tb/qdr_receiver_bench.sv
module qdr_receiver_bench;
    localparam int DEPTH  = 32;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = $clog2(DEPTH) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       fifo_data;
    logic [CNT_W-1:0]  fifo_count;
    logic              fifo_pop;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [127:0]      mem_wdata;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_sel = 2'd0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       ctrl_o;
    logic [ADDR_W-1:0] addr_o;
    logic [15:0]       qwc_o;
    logic              irq;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0]  fq [0:255];
    int           wr_p = 0;
    int           rd_p = 0;
    logic [ADDR_W-1:0] log_a [0:63];
    logic [127:0] log_d [0:63];
    int           n_wr  = 0;
    int           n_irq = 0;

    always #2 clk = ~clk;

    assign fifo_count = CNT_W'(wr_p - rd_p);
    assign fifo_data  = fq[rd_p % 256];

    qdr_receiver #(.FIFO_DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_qdr_receiver (
        .clk(clk), .rst_n(rst_n),
        .fifo_data(fifo_data), .fifo_count(fifo_count), .fifo_pop(fifo_pop),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ctrl_o(ctrl_o), .addr_o(addr_o), .qwc_o(qwc_o), .irq(irq)
    );

    always @(posedge clk) begin
        if (fifo_pop) rd_p <= rd_p + 1;
        if (mem_we) begin
            log_a[n_wr % 64] <= mem_addr;
            log_d[n_wr % 64] <= mem_wdata;
            n_wr <= n_wr + 1;
        end
        if (irq) n_irq <= n_irq + 1;
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FIFO-RX FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        fq[wr_p % 256] = w;
        wr_p = wr_p + 1;
    endtask

    task automatic push_tag(input logic [31:0] w0, input logic [31:0] w1);
        push(w0); push(w1); push(32'hAAAA_0002); push(32'hAAAA_0003);
    endtask

    task automatic push_qw(input logic [31:0] base);
        for (int i = 0; i < 4; i++) push(base + 32'(i));
    endtask

    function automatic logic [127:0] qw_of(input logic [31:0] base);
        return {base + 32'd3, base + 32'd2, base + 32'd1, base};
    endfunction

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(input string req);
        int start_irq = n_irq;
        int t = 0;
        while (n_irq == start_irq && t < 400) begin
            @(negedge clk);
            t++;
        end
        check(req, 128'(n_irq - start_irq), 128'd1);
        idle(2);
    endtask

    task automatic t_reset;
        check("R1 ctrl", 128'(ctrl_o), 128'd0);
        check("R1 addr", 128'(addr_o), 128'd0);
        check("R1 qwc", 128'(qwc_o), 128'd0);
        check("R1 strobes", 128'({irq, mem_we, fifo_pop}), 128'd0);
    endtask

    task automatic t_single_end;
        int w0 = n_wr;
        push_tag(32'h4000_0002, 32'h0000_1000);
        push_qw(32'h1100_0000);
        push_qw(32'h2200_0000);
        reg_write(2'd0, 32'h0000_0105);
        wait_irq("R6 irq after last block");
        check("R4 two writes", 128'(n_wr - w0), 128'd2);
        check("R4 addr0", 128'(log_a[w0 % 64]), 128'h1000);
        check("R4 data0", log_d[w0 % 64], qw_of(32'h1100_0000));
        check("R4 addr1", 128'(log_a[(w0 + 1) % 64]), 128'h1010);
        check("R4 data1", log_d[(w0 + 1) % 64], qw_of(32'h2200_0000));
        check("R3 ctrl upper copied lower kept", 128'(ctrl_o), 128'h4000_0005);
        check("R2 addr final", 128'(addr_o), 128'h1020);
        check("R2 qwc final", 128'(qwc_o), 128'd0);
        check("R6 fifo drained", 128'(fifo_count), 128'd0);
    endtask

    task automatic t_chain_two;
        int w0 = n_wr;
        push_tag(32'h1000_0001, 32'h0000_2000);
        push_qw(32'h3300_0000);
        push_tag(32'h7000_0001, 32'h0000_3000);
        push_qw(32'h4400_0000);
        reg_write(2'd0, 32'h0000_0100);
        wait_irq("R9 restart after last block runs");
        check("R9 writes across two tags", 128'(n_wr - w0), 128'd2);
        check("R2 second tag address", 128'(log_a[(w0 + 1) % 64]), 128'h3000);
        check("R4 second data", log_d[(w0 + 1) % 64], qw_of(32'h4400_0000));
        check("R3 ctrl from second tag", 128'(ctrl_o), 128'h7000_0000);
    endtask

    task automatic t_tag_irq;
        int w0 = n_wr;
        push_tag(32'h8000_0001, 32'h0000_5000);
        push_qw(32'h5500_0000);
        push_tag(32'h4000_0000, 32'h0000_6000);
        reg_write(2'd0, 32'h0000_0100);
        wait_irq("R7 tag interrupt stop");
        check("R7 one write", 128'(n_wr - w0), 128'd1);
        check("R7 next tag left in FIFO", 128'(fifo_count), 128'd4);
        check("R7 start cleared", 128'(ctrl_o[8]), 128'd0);
        reg_write(2'd0, 32'h8000_0100);
        wait_irq("R8 bit31 before first tag ignored");
        check("R8 tag consumed", 128'(fifo_count), 128'd0);
        check("R8 zero-count end tag no write", 128'(n_wr - w0), 128'd1);
        check("R8 ctrl from tag", 128'(ctrl_o), 128'h4000_0000);
        check("R2 address from zero-count tag", 128'(addr_o), 128'h6000);
    endtask

    task automatic t_fill_limited;
        int w0 = n_wr;
        int i0 = n_irq;
        push_tag(32'h4000_0003, 32'h0000_4000);
        push_qw(32'h6600_0000);
        reg_write(2'd0, 32'h0000_0100);
        idle(30);
        check("R5 partial burst writes", 128'(n_wr - w0), 128'd1);
        check("R5 qwc waits", 128'(qwc_o), 128'd2);
        check("R5 no irq while waiting", 128'(n_irq - i0), 128'd0);
        push(32'h7700_0000); push(32'h7700_0001); push(32'h7700_0002);
        idle(20);
        check("R5 no pop below four words", 128'(fifo_count), 128'd3);
        reg_write(2'd1, 32'hDEAD_0000);
        reg_write(2'd2, 32'h0000_0009);
        check("R10 addr write ignored while busy", 128'(addr_o), 128'h4010);
        check("R10 qwc write ignored while busy", 128'(qwc_o), 128'd2);
        push(32'h7700_0003);
        push_qw(32'h8800_0000);
        wait_irq("R5 completes after refill");
        check("R5 total writes", 128'(n_wr - w0), 128'd3);
        check("R4 data after stall", log_d[(w0 + 1) % 64], qw_of(32'h7700_0000));
        check("R4 final addr", 128'(addr_o), 128'h4030);
    endtask

    task automatic t_preload;
        int w0 = n_wr;
        reg_write(2'd1, 32'h0000_9000);
        reg_write(2'd2, 32'h0000_0001);
        check("R10 addr write idle", 128'(addr_o), 128'h9000);
        check("R10 qwc write idle", 128'(qwc_o), 128'd1);
        push_qw(32'h9900_0000);
        push_tag(32'h4000_0000, 32'h0000_A000);
        reg_write(2'd0, 32'h0000_0100);
        wait_irq("R11 preload then tag");
        check("R11 one write", 128'(n_wr - w0), 128'd1);
        check("R11 programmed address", 128'(log_a[w0 % 64]), 128'h9000);
        check("R11 programmed data", log_d[w0 % 64], qw_of(32'h9900_0000));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FIFO-RX FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_single_end();
        t_chain_two();
        t_tag_irq();
        t_fill_limited();
        t_preload();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule